// File: doc/BRIEF.md
# Drift-Correcting Delta Tick Generator

This block produces the delta strobe that paces a time-aware egress schedule engine. It counts raw oscillator ticks. With no error pending, it emits a one-cycle strobe every 25 ticks. Alongside the tick count it watches a time-of-day value that a rate servo may speed up or slow down. The schedule therefore has to stay phase-locked to that clock and not to the raw oscillator.

The time-of-day input is given in tick units. The block arms when it is enabled, and it starts on the first clock edge at which the time-of-day value is at or past the programmed start time.

The correction interval is programmed in time-of-day units. Once that much time-of-day has passed since the previous boundary, the block compares the time-of-day that elapsed with the number of ticks that were counted. It adds the difference to a signed error accumulator. The deltas that follow are then shortened or lengthened by whole ticks, with a bounded step per delta, until the error is gone. An interval of zero turns correction off.

A step of the time-of-day clock is too large to be absorbed. The accumulator then saturates and raises a sticky overflow flag, and the schedule has to be stopped and restarted.

Top module: `delta_tick_gen`

## Requirements
- R1: After reset, `strobe_o` and `drift_ovf_o` are 0.
- R2: While enabled and idle, no strobe appears until an edge at which `tod_i >= start_tod_i`. That edge is the start edge, and the first strobe appears exactly 25 edges after it.
- R3: If `tod_i` advances by exactly 1 per tick, every delta (the spacing between consecutive strobes) is 25 ticks.
- R4: A correction boundary occurs at the first edge where the time-of-day elapsed since the last boundary (or since the start) is at least `corr_period_i`. At that edge the error gains (time-of-day elapsed) minus (ticks elapsed).
- R5: Each new delta has length 25 − a, where a is the error clamped to ±5, and a is subtracted from the error. A positive error (time-of-day ahead) shortens deltas; a negative error lengthens them.
- R6: Every delta lies between 20 and 30 ticks (at most 5 ticks of adjustment per delta).
- R7: Once the error has drained to zero and time-of-day runs at the nominal rate, deltas return to 25 ticks.
- R8: With `corr_period_i` = 0, no error is accumulated and every delta is 25 ticks, whatever the rate of the time-of-day clock.
- R9: The error saturates at ±64. An update that would pass that limit sets `drift_ovf_o`, which stays set until reset, including across a stop and restart.
- R10: Deasserting `en_i` stops the strobes from the next edge and clears the error. After re-enabling, the block waits for the start time again.
- R11: The strobe is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator tick clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Enables the schedule; low stops it |
| tod_i | input | TOD_W (32) | Time-of-day value in tick units |
| start_tod_i | input | TOD_W (32) | Time-of-day at which the schedule starts |
| corr_period_i | input | PER_W (16) | Correction interval in time-of-day units; 0 turns correction off |
| strobe_o | output | 1 | One-cycle pulse at the end of each delta |
| drift_ovf_o | output | 1 | Sticky flag: the error passed the saturation limit |

## Verification
The bench runs a behavioural model next to the design and drives the time-of-day clock fast, slow, nominal and with a large step.

If the correction sign were inverted, a fast time-of-day would produce deltas longer than 25, and the bench would catch it. If the slew clamp were missing, deltas would fall outside 20 to 30. If the period-zero bypass were broken, deltas would drift away from 25 even though correction is off. If the overflow flag were not sticky, it would clear on the restart that follows the step.

The bench also checks that a restart waits for the new start time, and that the first delta after the start edge is exactly 25 ticks. A start that was off by one edge would shift every later strobe.

// File: rtl/delta_tick_gen_pkg.sv
package delta_tick_gen_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

endpackage

// File: rtl/dtg_delta_timer.sv
module dtg_delta_timer #(
    parameter int NOM_TICKS = 25,
    parameter int SLEW_MAX  = 5,
    parameter int CNT_W     = 5,
    parameter int ADJ_W     = 4
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    run_i,
    input  logic                    start_i,
    input  logic signed [ADJ_W-1:0] adj_i,
    output logic                    reload_o,
    output logic                    strobe_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             strobe;
    } tmr_state_t;

    tmr_state_t st_d, st_q;
    logic [CNT_W-1:0] next_len;

    always_comb begin
        next_len    = CNT_W'(NOM_TICKS - int'(adj_i));
        reload_o    = run_i && (st_q.cnt == CNT_W'(1));
        st_d        = st_q;
        st_d.strobe = 1'b0;
        if (start_i) begin
            st_d.cnt = CNT_W'(NOM_TICKS);
        end else if (!run_i) begin
            st_d.cnt = '0;
        end else if (reload_o) begin
            st_d.cnt    = next_len;
            st_d.strobe = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign strobe_o = st_q.strobe;

    // R6: a running countdown never leaves the slewed window
    p_len_bounds_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_i |-> (st_q.cnt >= CNT_W'(1) && st_q.cnt <= CNT_W'(NOM_TICKS + SLEW_MAX)));

    // R11: the strobe is a single-cycle pulse
    p_strobe_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.strobe |=> !st_q.strobe);

endmodule

// File: rtl/dtg_drift_meter.sv
module dtg_drift_meter #(
    parameter int TOD_W = 32,
    parameter int PER_W = 16
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  run_i,
    input  logic                  start_i,
    input  logic [TOD_W-1:0]      tod_i,
    input  logic [PER_W-1:0]      period_i,
    output logic                  bnd_o,
    output logic signed [TOD_W:0] drift_o
);

    typedef struct packed {
        logic [TOD_W-1:0] base;
        logic [TOD_W-1:0] ticks;
    } mtr_state_t;

    mtr_state_t st_d, st_q;
    logic [TOD_W-1:0] tod_elapsed;
    logic [TOD_W-1:0] tick_elapsed;

    always_comb begin
        tod_elapsed  = tod_i - st_q.base;
        tick_elapsed = st_q.ticks + TOD_W'(1);
        bnd_o        = 1'b0;
        drift_o      = '0;
        st_d         = st_q;
        if (start_i) begin
            st_d.base  = tod_i;
            st_d.ticks = '0;
        end else if (run_i) begin
            if (period_i == '0) begin
                st_d.base  = tod_i;
                st_d.ticks = '0;
            end else if (tod_elapsed >= TOD_W'(period_i)) begin
                bnd_o      = 1'b1;
                drift_o    = $signed({1'b0, tod_elapsed}) - $signed({1'b0, tick_elapsed});
                st_d.base  = tod_i;
                st_d.ticks = '0;
            end else begin
                st_d.ticks = tick_elapsed;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // R4: a boundary restarts the tick count of the next interval
    p_rebase_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bnd_o && !start_i) |=> (st_q.ticks == '0));

endmodule

// File: rtl/dtg_err_accum.sv
module dtg_err_accum #(
    parameter int TOD_W     = 32,
    parameter int ERR_LIMIT = 64,
    parameter int SLEW_MAX  = 5,
    parameter int ERR_W     = 8,
    parameter int ADJ_W     = 4
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    run_i,
    input  logic                    reload_i,
    input  logic                    bnd_i,
    input  logic signed [TOD_W:0]   drift_i,
    output logic signed [ADJ_W-1:0] adj_o,
    output logic signed [ERR_W-1:0] err_o,
    output logic                    ovf_o
);

    localparam int SUM_W = TOD_W + 3;

    typedef struct packed {
        logic signed [ERR_W-1:0] err;
        logic                    ovf;
    } acc_state_t;

    acc_state_t st_d, st_q;
    logic signed [SUM_W-1:0] sum;
    logic signed [SUM_W-1:0] lim_pos;
    logic signed [SUM_W-1:0] lim_neg;

    always_comb begin
        if (st_q.err > ERR_W'(SLEW_MAX))
            adj_o = ADJ_W'(SLEW_MAX);
        else if (st_q.err < ERR_W'(-SLEW_MAX))
            adj_o = ADJ_W'(-SLEW_MAX);
        else
            adj_o = st_q.err[ADJ_W-1:0];

        lim_pos = SUM_W'(ERR_LIMIT);
        lim_neg = SUM_W'(-ERR_LIMIT);
        sum     = SUM_W'(st_q.err);
        if (reload_i) sum = sum - SUM_W'(adj_o);
        if (bnd_i)    sum = sum + SUM_W'(drift_i);

        st_d = st_q;
        if (!run_i) begin
            st_d.err = '0;
        end else if (sum > lim_pos) begin
            st_d.err = ERR_W'(ERR_LIMIT);
            st_d.ovf = 1'b1;
        end else if (sum < lim_neg) begin
            st_d.err = ERR_W'(-ERR_LIMIT);
            st_d.ovf = 1'b1;
        end else begin
            st_d.err = sum[ERR_W-1:0];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign err_o = st_q.err;
    assign ovf_o = st_q.ovf;

    // R9: the stored error never passes the saturation limit
    p_err_range_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.err <= ERR_W'(ERR_LIMIT)) && (st_q.err >= ERR_W'(-ERR_LIMIT)));

    // R9: the overflow flag is sticky
    p_ovf_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.ovf |=> st_q.ovf);

    // R5: a delta reload with no new drift moves a positive error towards zero
    p_drain_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && reload_i && !bnd_i && st_q.err > 0) |=> (st_q.err < $past(st_q.err)));

endmodule

// File: rtl/delta_tick_gen.sv
module delta_tick_gen #(
    parameter int TOD_W     = 32,
    parameter int PER_W     = 16,
    parameter int NOM_TICKS = 25,
    parameter int SLEW_MAX  = 5,
    parameter int ERR_LIMIT = 64
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic [TOD_W-1:0] tod_i,
    input  logic [TOD_W-1:0] start_tod_i,
    input  logic [PER_W-1:0] corr_period_i,
    output logic             strobe_o,
    output logic             drift_ovf_o
);
    import delta_tick_gen_pkg::*;

    localparam int CNT_W = $clog2(NOM_TICKS + SLEW_MAX + 1);
    localparam int ERR_W = $clog2(ERR_LIMIT + 1) + 1;
    localparam int ADJ_W = $clog2(SLEW_MAX + 1) + 1;

    typedef struct packed {
        run_state_e run;
    } top_state_t;

    top_state_t st_d, st_q;
    logic start_go;
    logic live;
    logic reload;
    logic bnd;
    logic signed [TOD_W:0]   drift;
    logic signed [ADJ_W-1:0] adj;
    logic signed [ERR_W-1:0] err;

    always_comb begin
        live     = en_i && (st_q.run == ST_RUN);
        start_go = en_i && (st_q.run == ST_IDLE) && (tod_i >= start_tod_i);
        st_d     = st_q;
        if (!en_i)        st_d.run = ST_IDLE;
        else if (start_go) st_d.run = ST_RUN;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{run: ST_IDLE};
        else         st_q <= st_d;
    end

    dtg_delta_timer #(
        .NOM_TICKS(NOM_TICKS), .SLEW_MAX(SLEW_MAX), .CNT_W(CNT_W), .ADJ_W(ADJ_W)
    ) u_timer (
        .clk_i(clk_i), .rst_ni(rst_ni), .run_i(live), .start_i(start_go),
        .adj_i(adj), .reload_o(reload), .strobe_o(strobe_o)
    );

    dtg_drift_meter #(
        .TOD_W(TOD_W), .PER_W(PER_W)
    ) u_meter (
        .clk_i(clk_i), .rst_ni(rst_ni), .run_i(live), .start_i(start_go),
        .tod_i(tod_i), .period_i(corr_period_i), .bnd_o(bnd), .drift_o(drift)
    );

    dtg_err_accum #(
        .TOD_W(TOD_W), .ERR_LIMIT(ERR_LIMIT), .SLEW_MAX(SLEW_MAX),
        .ERR_W(ERR_W), .ADJ_W(ADJ_W)
    ) u_accum (
        .clk_i(clk_i), .rst_ni(rst_ni), .run_i(live), .reload_i(reload),
        .bnd_i(bnd), .drift_i(drift), .adj_o(adj), .err_o(err), .ovf_o(drift_ovf_o)
    );

    // R10: disabling stops the strobe from the next edge
    p_stop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> !strobe_o);

    // R2: no strobe while the schedule has not started
    p_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.run == ST_IDLE) |-> !strobe_o);

    // R8: with correction off, a clean error stays clean
    p_period_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (live && corr_period_i == '0 && err == '0) |=> (err == '0));

endmodule

// File: tb/delta_tick_gen_bench.sv
module delta_tick_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [31:0] tod = '0;
    logic [31:0] start_tod = '0;
    logic [15:0] period = '0;
    logic        strobe;
    logic        ovf;

    int checks = 0;
    int fails = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    delta_tick_gen u_delta_tick_gen (
        .clk_i(clk), .rst_ni(rst_n), .en_i(en), .tod_i(tod),
        .start_tod_i(start_tod), .corr_period_i(period),
        .strobe_o(strobe), .drift_ovf_o(ovf)
    );

    // behavioural reference model
    bit          m_run, m_strobe, m_ovf;
    int          m_cnt, m_err, m_tick;
    logic [31:0] m_base;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_strobe = 0; m_ovf = 0; m_cnt = 0; m_err = 0;
            m_tick = 0; m_base = '0;
        end else if (!en) begin
            m_run = 0; m_strobe = 0; m_cnt = 0; m_err = 0;
        end else if (!m_run) begin
            m_strobe = 0;
            if (tod >= start_tod) begin
                m_run = 1; m_cnt = 25; m_base = tod; m_tick = 0; m_err = 0;
            end
        end else begin
            int a, s;
            logic [31:0] el;
            a = (m_err > 5) ? 5 : ((m_err < -5) ? -5 : m_err);
            s = m_err;
            m_strobe = (m_cnt == 1);
            if (m_cnt == 1) begin m_cnt = 25 - a; s = s - a; end
            else m_cnt = m_cnt - 1;
            el = tod - m_base;
            if (period == 0) begin m_base = tod; m_tick = 0; end
            else if (el >= {16'h0, period}) begin
                s = s + (int'(el) - (m_tick + 1));
                m_base = tod; m_tick = 0;
            end else m_tick = m_tick + 1;
            if (s > 64) begin s = 64; m_ovf = 1; end
            if (s < -64) begin s = -64; m_ovf = 1; end
            m_err = s;
        end
    end

    // per-cycle comparison and delta statistics
    int cyc = 0, last_st = 0, gap_min = 1000, gap_max = 0, n_strobe = 0;
    bit have_last = 0, prev_strobe = 0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            checks++;
            if (strobe !== m_strobe || ovf !== m_ovf) begin
                fails++;
                $display("FAIL %s cycle %0d strobe=%0b ovf=%0b expected strobe=%0b ovf=%0b",
                         cur_req, cyc, strobe, ovf, m_strobe, m_ovf);
            end
            if (prev_strobe && strobe) begin
                checks++; fails++;
                $display("FAIL R11 back-to-back strobe got 1 expected 0");
            end
            prev_strobe = strobe;
            if (strobe === 1'b1) begin
                n_strobe++;
                if (have_last) begin
                    if (cyc - last_st < gap_min) gap_min = cyc - last_st;
                    if (cyc - last_st > gap_max) gap_max = cyc - last_st;
                end
                have_last = 1; last_st = cyc;
            end
        end
    end

    task automatic clear_stats(bit fresh);
        gap_min = 1000; gap_max = 0; n_strobe = 0;
        if (fresh) have_last = 0;
    endtask

    task automatic chk(string req, int got, int exp_v, string what);
        checks++;
        if (got != exp_v) begin
            fails++;
            $display("FAIL %s %s got %0d expected %0d", req, what, got, exp_v);
        end
    endtask

    task automatic chk_true(string req, bit cond, int got, string what);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s %s got %0d expected condition to hold", req, what, got);
        end
    endtask

    // mode 0 nominal, 1 fast (extra tick every 10), 2 slow (skip every 10)
    task automatic run_ticks(int n, int mode);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (mode == 1 && (k % 10) == 9)      tod = tod + 2;
            else if (mode == 2 && (k % 10) == 9) tod = tod;
            else                                 tod = tod + 1;
        end
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired got timeout expected completion");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", strobe, 0, "strobe after reset");
        chk("R1", ovf, 0, "overflow after reset");

        // R2 / R3: start gating then nominal deltas
        cur_req = "R2";
        start_tod = 32'd200; period = 16'd100; en = 1'b1;
        clear_stats(1);
        run_ticks(190, 0);
        chk("R2", n_strobe, 0, "strobes before start time");
        cur_req = "R3";
        run_ticks(700, 0);
        chk("R3", gap_min, 25, "shortest nominal delta");
        chk("R3", gap_max, 25, "longest nominal delta");

        // R4 / R5 / R6: time-of-day running fast
        cur_req = "R5"; clear_stats(0);
        run_ticks(1500, 1);
        chk_true("R5", gap_min < 25, gap_min, "fast clock shortens deltas");
        chk_true("R6", gap_min >= 20 && gap_max <= 30, gap_min, "fast slew window");
        chk("R4", ovf, 0, "no overflow on small drift");

        // R7: back to nominal rate
        cur_req = "R7";
        run_ticks(400, 0);
        clear_stats(0);
        run_ticks(300, 0);
        chk("R7", gap_min, 25, "resumed delta min");
        chk("R7", gap_max, 25, "resumed delta max");

        // R5 / R6: time-of-day running slow
        cur_req = "R6"; clear_stats(0);
        run_ticks(1500, 2);
        chk_true("R5", gap_max > 25, gap_max, "slow clock lengthens deltas");
        chk_true("R6", gap_min >= 20 && gap_max <= 30, gap_max, "slow slew window");

        // R8: correction off with fast clock
        cur_req = "R8";
        en = 1'b0; run_ticks(3, 0);
        period = 16'd0; start_tod = tod + 10; en = 1'b1;
        clear_stats(1);
        run_ticks(1500, 1);
        chk("R8", gap_min, 25, "period zero delta min");
        chk("R8", gap_max, 25, "period zero delta max");

        // R10: stop and restart waits for new start time
        cur_req = "R10";
        en = 1'b0; clear_stats(1);
        run_ticks(30, 0);
        chk("R10", n_strobe, 0, "strobes while disabled");
        start_tod = tod + 300; period = 16'd100; en = 1'b1;
        run_ticks(290, 0);
        chk("R10", n_strobe, 0, "strobes before restart time");
        run_ticks(200, 0);
        chk_true("R10", n_strobe > 0, n_strobe, "strobes after restart");
        chk("R10", gap_min, 25, "delta after restart");

        // R9: time-of-day step saturates and flags overflow
        cur_req = "R9"; clear_stats(0);
        @(negedge clk); tod = tod + 1000;
        run_ticks(600, 0);
        chk("R9", ovf, 1, "overflow after step");
        chk("R9", gap_min, 20, "saturated error uses full slew");
        en = 1'b0; run_ticks(5, 0);
        start_tod = tod + 20; en = 1'b1;
        run_ticks(100, 0);
        chk("R9", ovf, 1, "overflow sticky across restart");

        summary();
    end

endmodule